// File: doc/BRIEF.md
# Coherence Event Dispatcher

This block sits in front of a per-line cache coherence controller and turns three incoming message queues into a single event per cycle. The queues carry responses (data and invalidation acknowledgements), requests forwarded by the home directory, and processor requests. Each queue presents its head message as a valid flag, a type code and an address. The dispatcher picks one head by fixed priority, decodes its type into an event code, and puts the event on its output with the line address it applies to. When the controller takes the event, the dispatcher pops the source queue.

Processor requests arrive with byte addresses. The dispatcher drops the offset bits to form the line address, which goes to the tag lookup and to a comparison against the in-flight transaction table. A processor request whose line is still in flight waits at the head of its queue. If the request misses and its set has no free way, the dispatcher issues a replacement event on the victim line chosen by the replacement logic. The request itself stays queued until room exists. A message with an undefined type is discarded, and a one-cycle error flag follows it.

Top module: `coh_event_dispatch`

## Requirements
- R1: Responses have priority over forwarded requests, and forwarded requests have priority over processor requests. A queue is served only in a cycle when every higher-priority queue has no valid head.
- R2: Forwarded type codes decode as follows: 0 (read-share request) gives event 4, 1 (ownership request) gives event 5, 2 (invalidate) gives event 6, and 3 (put acknowledgement) gives event 7. The event line is the forwarded line address.
- R3: Processor type codes decode as follows: 0 (load) and 1 (instruction fetch) give event 1, and 2 (store) gives event 2. The event line is the aligned processor line.
- R4: A response type of 3, a forwarded type of 4 to 7, or a processor type of 3 is undefined. In that cycle evtValid stays low and the source queue is popped, even when ctrlStall is high. errFlag is high for exactly the following cycle.
- R5: Suppose a processor request with a defined type is served while lookupHit is low and setFull is high. The block then issues event 3 on victimLine and does not pop the processor queue.
- R6: While any entry with tbeValid set holds a line equal to the processor request's line, that request produces no event, no pop and no error. Entries with tbeValid clear are ignored.
- R7: lookupLine equals procAddr with its low LINE_OFF bits removed. Two byte addresses in the same line behave identically.
- R8: While ctrlStall is high, an issued event pops nothing, and the same event stays offered for as long as the inputs hold.
- R9: At most one pop strobe is high in a cycle. A pop strobe is high only for the queue whose head was selected.
- R10: Response type codes decode as follows: 0 (data from home) gives event 8, 1 (data from a peer cache) gives event 9, and 2 (invalidation acknowledgement) gives event 10. The event line is the response line address.
- R11: In the cycle after reset is released, errFlag is low. With no valid head, evtValid is low, evtCode is 0 and no pop is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rspValid | input | 1 | Response queue head is valid |
| rspType | input | 2 | Response type code |
| rspLine | input | LINE_W | Response line address |
| rspPop | output | 1 | Pop the response queue |
| fwdValid | input | 1 | Forwarded queue head is valid |
| fwdType | input | 3 | Forwarded type code |
| fwdLine | input | LINE_W | Forwarded line address |
| fwdPop | output | 1 | Pop the forwarded queue |
| procValid | input | 1 | Processor queue head is valid |
| procType | input | 2 | Processor type code |
| procAddr | input | ADDR_W | Processor byte address |
| procPop | output | 1 | Pop the processor queue |
| tbeValid | input | TBE_N | Valid bits of the in-flight transaction entries |
| tbeLine | input | TBE_N*LINE_W | Line addresses of the in-flight entries, entry i at bits i*LINE_W and up |
| lookupLine | output | LINE_W | Aligned processor line sent to the tag lookup |
| lookupHit | input | 1 | The lookup line is present in the cache |
| setFull | input | 1 | The lookup set has no free way |
| victimLine | input | LINE_W | Victim line chosen by the replacement logic |
| evtValid | output | 1 | An event is offered |
| evtCode | output | 4 | Event code |
| evtLine | output | LINE_W | Line the event applies to |
| ctrlStall | input | 1 | The controller cannot take the offered event this cycle |
| errFlag | output | 1 | An undefined message was discarded in the previous cycle |

## Verification
Selection, decoding, the event outputs, lookupLine and all three pop strobes are combinational. They are due in the same cycle the head inputs and ctrlStall are applied. errFlag comes from a register and is due one rising edge after the undefined message is popped. The bench changes inputs on the falling edge and reads the combinational results a quarter period before the next rising edge. It compares errFlag against the expectation carried over from the previous step of the sweep.

// File: rtl/coh_disp_pkg.sv
package coh_disp_pkg;

  typedef enum logic [3:0] {
    EV_NONE       = 4'd0,
    EV_LOAD       = 4'd1,
    EV_STORE      = 4'd2,
    EV_REPLACE    = 4'd3,
    EV_FWD_SHARE  = 4'd4,
    EV_FWD_OWN    = 4'd5,
    EV_INVAL      = 4'd6,
    EV_PUT_DONE   = 4'd7,
    EV_DATA_HOME  = 4'd8,
    EV_DATA_PEER  = 4'd9,
    EV_INV_ACK    = 4'd10
  } evt_e;

  // response type codes
  localparam logic [1:0] RSP_DATA_HOME = 2'd0;
  localparam logic [1:0] RSP_DATA_PEER = 2'd1;
  localparam logic [1:0] RSP_INV_ACK   = 2'd2;

  // forwarded type codes
  localparam logic [2:0] FWD_SHARE    = 3'd0;
  localparam logic [2:0] FWD_OWN      = 3'd1;
  localparam logic [2:0] FWD_INVAL    = 3'd2;
  localparam logic [2:0] FWD_PUT_DONE = 3'd3;

  // processor type codes
  localparam logic [1:0] PROC_LOAD  = 2'd0;
  localparam logic [1:0] PROC_FETCH = 2'd1;
  localparam logic [1:0] PROC_STORE = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic selRsp;
    logic selFwd;
    logic selProc;
    logic useVictim;
    logic raiseErr;
  } disp_strobe_t;

endpackage

// File: rtl/coh_disp_datapath.sv
module coh_disp_datapath
  import coh_disp_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int LINE_OFF = 4,
  parameter int TBE_N    = 4,
  localparam int LINE_W  = ADDR_W - LINE_OFF
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  disp_strobe_t            strobe,
  input  logic [LINE_W-1:0]       rspLine,
  input  logic [LINE_W-1:0]       fwdLine,
  input  logic [ADDR_W-1:0]       procAddr,
  input  logic [TBE_N-1:0]        tbeValid,
  input  logic [TBE_N*LINE_W-1:0] tbeLine,
  input  logic [LINE_W-1:0]       victimLine,
  output logic [LINE_W-1:0]       procLine,
  output logic                    procBlocked,
  output logic [LINE_W-1:0]       evtLine,
  output logic                    errFlag
);

  logic [LINE_OFF-1:0] byteOffsetUnused;
  logic [TBE_N-1:0]    lineMatch;

  assign procLine         = procAddr[ADDR_W-1:LINE_OFF];
  assign byteOffsetUnused = procAddr[LINE_OFF-1:0];

  // one comparator per in-flight entry
  for (genvar i = 0; i < TBE_N; i++) begin : gMatch
    assign lineMatch[i] = tbeValid[i] && (tbeLine[i*LINE_W +: LINE_W] == procLine);
  end

  assign procBlocked = |lineMatch;

  always_comb begin
    if (strobe.useVictim)   evtLine = victimLine;
    else if (strobe.selRsp) evtLine = rspLine;
    else if (strobe.selFwd) evtLine = fwdLine;
    else                    evtLine = procLine;
  end

  always_ff @(posedge clk) begin
    if (!rstN) errFlag <= 1'b0;
    else       errFlag <= strobe.raiseErr;
  end

  AST_VICTIM_ONLY_PROC: assert property (@(posedge clk) disable iff (!rstN)
    strobe.useVictim |-> (strobe.selProc && !procBlocked)) else $error("victim without proc"); // R5

endmodule

// File: rtl/coh_disp_control.sv
module coh_disp_control
  import coh_disp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rspValid,
  input  logic [1:0]   rspType,
  input  logic         fwdValid,
  input  logic [2:0]   fwdType,
  input  logic         procValid,
  input  logic [1:0]   procType,
  input  logic         procBlocked,
  input  logic         lookupHit,
  input  logic         setFull,
  input  logic         ctrlStall,
  output disp_strobe_t strobe,
  output logic         evtValid,
  output evt_e         evtCode,
  output logic         rspPop,
  output logic         fwdPop,
  output logic         procPop
);

  logic decErr;
  logic anySel;
  logic accept;

  always_comb begin
    strobe  = '0;
    evtCode = EV_NONE;
    decErr  = 1'b0;
    if (rspValid) begin
      strobe.selRsp = 1'b1;
      case (rspType)
        RSP_DATA_HOME: evtCode = EV_DATA_HOME;
        RSP_DATA_PEER: evtCode = EV_DATA_PEER;
        RSP_INV_ACK:   evtCode = EV_INV_ACK;
        default:       decErr  = 1'b1;
      endcase
    end else if (fwdValid) begin
      strobe.selFwd = 1'b1;
      case (fwdType)
        FWD_SHARE:    evtCode = EV_FWD_SHARE;
        FWD_OWN:      evtCode = EV_FWD_OWN;
        FWD_INVAL:    evtCode = EV_INVAL;
        FWD_PUT_DONE: evtCode = EV_PUT_DONE;
        default:      decErr  = 1'b1;
      endcase
    end else if (procValid && !procBlocked) begin
      strobe.selProc = 1'b1;
      case (procType)
        PROC_LOAD, PROC_FETCH: evtCode = EV_LOAD;
        PROC_STORE:            evtCode = EV_STORE;
        default:               decErr  = 1'b1;
      endcase
      if (!decErr && !lookupHit && setFull) begin
        evtCode          = EV_REPLACE;
        strobe.useVictim = 1'b1;
      end
    end
    strobe.raiseErr = decErr;
  end

  assign anySel   = strobe.selRsp || strobe.selFwd || strobe.selProc;
  assign evtValid = anySel && !decErr;
  assign accept   = decErr || (evtValid && !ctrlStall && !strobe.useVictim);
  assign rspPop   = strobe.selRsp  && accept;
  assign fwdPop   = strobe.selFwd  && accept;
  assign procPop  = strobe.selProc && accept;

  AST_SINGLE_POP: assert property (@(posedge clk) disable iff (!rstN)
    $countones({rspPop, fwdPop, procPop}) <= 1) else $error("multiple pops"); // R9
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && ctrlStall) |-> !(rspPop || fwdPop || procPop)) else $error("pop under stall"); // R8
  AST_RSP_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (!fwdPop && !procPop)) else $error("lower queue over response"); // R1
  AST_FWD_OVER_PROC: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> !procPop) else $error("proc over forward"); // R1
  AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (procBlocked && !rspValid && !fwdValid) |-> (!procPop && !evtValid)) else $error("blocked line served"); // R6
  AST_VICTIM_NO_POP: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtCode == EV_REPLACE) |-> !procPop) else $error("replacement popped"); // R5

endmodule

// File: rtl/coh_event_dispatch.sv
module coh_event_dispatch
  import coh_disp_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int LINE_OFF = 4,
  parameter int TBE_N    = 4,
  localparam int LINE_W  = ADDR_W - LINE_OFF
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    rspValid,
  input  logic [1:0]              rspType,
  input  logic [LINE_W-1:0]       rspLine,
  output logic                    rspPop,
  input  logic                    fwdValid,
  input  logic [2:0]              fwdType,
  input  logic [LINE_W-1:0]       fwdLine,
  output logic                    fwdPop,
  input  logic                    procValid,
  input  logic [1:0]              procType,
  input  logic [ADDR_W-1:0]       procAddr,
  output logic                    procPop,
  input  logic [TBE_N-1:0]        tbeValid,
  input  logic [TBE_N*LINE_W-1:0] tbeLine,
  output logic [LINE_W-1:0]       lookupLine,
  input  logic                    lookupHit,
  input  logic                    setFull,
  input  logic [LINE_W-1:0]       victimLine,
  output logic                    evtValid,
  output logic [3:0]              evtCode,
  output logic [LINE_W-1:0]       evtLine,
  input  logic                    ctrlStall,
  output logic                    errFlag
);

  disp_strobe_t strobe;
  logic         procBlocked;
  evt_e         evtKind;

  coh_disp_control uControl (
    .clk(clk), .rstN(rstN),
    .rspValid(rspValid), .rspType(rspType),
    .fwdValid(fwdValid), .fwdType(fwdType),
    .procValid(procValid), .procType(procType),
    .procBlocked(procBlocked), .lookupHit(lookupHit), .setFull(setFull),
    .ctrlStall(ctrlStall), .strobe(strobe), .evtValid(evtValid),
    .evtCode(evtKind), .rspPop(rspPop), .fwdPop(fwdPop), .procPop(procPop)
  );

  coh_disp_datapath #(.ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF), .TBE_N(TBE_N)) uDatapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rspLine(rspLine), .fwdLine(fwdLine), .procAddr(procAddr),
    .tbeValid(tbeValid), .tbeLine(tbeLine), .victimLine(victimLine),
    .procLine(lookupLine), .procBlocked(procBlocked),
    .evtLine(evtLine), .errFlag(errFlag)
  );

  assign evtCode = evtKind;

  AST_ERR_AFTER_DROP: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> $past((rspPop || fwdPop || procPop) && !evtValid)) else $error("error without drop"); // R4

endmodule

// File: tb/coh_event_dispatch_test.sv
`timescale 1ns/1ps
module coh_event_dispatch_test;

  localparam int ADDR_W   = 16;
  localparam int LINE_OFF = 4;
  localparam int TBE_N    = 4;
  localparam int LINE_W   = ADDR_W - LINE_OFF;
  localparam int HALF     = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rspValid = 0, fwdValid = 0, procValid = 0;
  logic [1:0] rspType = 0, procType = 0;
  logic [2:0] fwdType = 0;
  logic [LINE_W-1:0] rspLine = 0, fwdLine = 0, victimLine = 0;
  logic [ADDR_W-1:0] procAddr = 0;
  logic [TBE_N-1:0] tbeValid = 0;
  logic [TBE_N*LINE_W-1:0] tbeLine = 0;
  logic lookupHit = 0, setFull = 0, ctrlStall = 0;
  logic rspPop, fwdPop, procPop, evtValid, errFlag;
  logic [3:0] evtCode;
  logic [LINE_W-1:0] evtLine, lookupLine;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #HALF clk = ~clk;

  coh_event_dispatch #(.ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF), .TBE_N(TBE_N)) uut (
    .clk(clk), .rstN(rstN),
    .rspValid(rspValid), .rspType(rspType), .rspLine(rspLine), .rspPop(rspPop),
    .fwdValid(fwdValid), .fwdType(fwdType), .fwdLine(fwdLine), .fwdPop(fwdPop),
    .procValid(procValid), .procType(procType), .procAddr(procAddr), .procPop(procPop),
    .tbeValid(tbeValid), .tbeLine(tbeLine), .lookupLine(lookupLine),
    .lookupHit(lookupHit), .setFull(setFull), .victimLine(victimLine),
    .evtValid(evtValid), .evtCode(evtCode), .evtLine(evtLine),
    .ctrlStall(ctrlStall), .errFlag(errFlag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    bit prevErr;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #5;
    chk("R11 errFlag after reset", errFlag, 0);
    chk("R11 evtValid idle", evtValid, 0);
    chk("R11 evtCode idle", evtCode, 0);
    chk("R11 no pop idle", {rspPop, fwdPop, procPop}, 0);
    prevErr = 0;
    n = 0;
    for (int v = 0; v < 8; v++)
    for (int rt = 0; rt < 4; rt++)
    for (int ft = 0; ft < 8; ft++)
    for (int pt = 0; pt < 4; pt++)
    for (int st = 0; st < 2; st++)
    for (int bk = 0; bk < 2; bk++)
    for (int hf = 0; hf < 4; hf++) begin
      logic [LINE_W-1:0] pl;
      bit eV, eErr, eRp, eFp, ePp, eVict;
      int eC;
      logic [LINE_W-1:0] eL;
      string tag;
      @(negedge clk);
      n++;
      pl = LINE_W'(12'h300 + n * 7);
      rspValid  = v[0];
      fwdValid  = v[1];
      procValid = v[2];
      rspType   = 2'(rt);
      fwdType   = 3'(ft);
      procType  = 2'(pt);
      ctrlStall = st[0];
      lookupHit = hf[0];
      setFull   = hf[1];
      rspLine   = LINE_W'(12'h100 + n);
      fwdLine   = LINE_W'(12'h200 + n * 3);
      victimLine = LINE_W'(12'h800 ^ n);
      procAddr  = {pl, 4'(n * 5)};
      tbeLine   = {LINE_W'(pl + 2), pl, pl, pl ^ LINE_W'(1)};
      tbeValid  = {1'b1, 1'b0, bk[0], 1'b1};
      // expected per requirements
      eV = 0; eErr = 0; eRp = 0; eFp = 0; ePp = 0; eVict = 0; eC = 0; eL = pl;
      if (rspValid) begin
        tag = "R10";
        eL = rspLine;
        if (rt == 3) eErr = 1; else eC = 8 + rt;
        eV = !eErr;
        eRp = eErr || !st[0];
      end else if (fwdValid) begin
        tag = "R2";
        eL = fwdLine;
        if (ft > 3) eErr = 1; else eC = 4 + ft;
        eV = !eErr;
        eFp = eErr || !st[0];
      end else if (procValid && bk == 0) begin
        tag = "R3";
        if (pt == 3) begin eErr = 1; tag = "R4"; end
        else if (!hf[0] && hf[1]) begin eC = 3; eVict = 1; eL = victimLine; tag = "R5"; end
        else eC = (pt == 2) ? 2 : 1;
        eV = !eErr;
        ePp = eErr || (!st[0] && !eVict);
      end else if (procValid) begin
        tag = "R6";
      end else begin
        tag = "R11";
      end
      if (eErr) tag = "R4";
      #5;
      chk({tag, " evtValid"}, evtValid, eV);
      chk({tag, " evtCode"}, evtCode, eC);
      if (eV) chk({tag, " evtLine"}, evtLine, eL);
      chk({tag, " pops"}, {rspPop, fwdPop, procPop}, {eRp, eFp, ePp});
      chk("R7 lookupLine", lookupLine, pl);
      chk("R4 errFlag", errFlag, prevErr);
      chk("R9 one pop", ($countones({rspPop, fwdPop, procPop}) <= 1), 1);
      if (rspValid) chk("R1 lower queues idle", fwdPop || procPop, 0);
      if (fwdValid) chk("R1 proc idle", procPop, 0);
      if (st[0] && eV) chk("R8 stalled no pop", rspPop || fwdPop || procPop, 0);
      prevErr = eErr;
    end
    @(negedge clk);
    rspValid = 0; fwdValid = 0; procValid = 0;
    #5;
    chk("R4 errFlag last", errFlag, prevErr);
    @(negedge clk);
    #5;
    chk("R4 errFlag clears", errFlag, 0);
    finish_run();
  end

endmodule